// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block is a 32-entry translation cache that maps 32-bit virtual addresses to physical addresses. Each entry covers one of four page sizes (4 KB, 64 KB, 1 MB or 16 MB), and entries of all four sizes share one associative array. Software maintains the array through staging registers. It writes a tag word and a data word, then pulses a load strobe. The staged pair is written into the slot that the replacement pointer selects.

Replacement uses a locked floor and a rotating pointer. Slots below the floor are kept for pinned translations. After each load the pointer moves up by one, and after the last slot it returns to the floor. Software can also set the pointer directly.

Entries can be removed in two ways. A single flush removes the slots that match a staged tag at its page size. A global flush clears every slot except those marked as kept. Lookup is combinational. If several slots match, the lowest-numbered one wins.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no slot is valid, the floor and the pointer read 0, and every lookup misses.
- R2: On a tag-word write, the staged tag word takes its fields from these bits: virtual tag [31:12], keep flag [3], valid flag [2], size code [1:0]. On a load pulse, the staged tag and data words are written into the slot the pointer selects, with the staged valid flag.
- R3: The size code selects which virtual-address bits a slot compares: code 0 (1 MB) uses VA[31:20], code 1 (64 KB) uses VA[31:16], code 2 (4 KB) uses VA[31:12], and code 3 (16 MB) uses VA[31:24].
- R4: On a hit, the output address takes the slot's physical base in the compared bits and the virtual address in all lower bits. The data word supplies the physical base [31:12], endianness [9], element size [8:7] and mixed flag [6], and these appear on the attribute outputs.
- R5: After each load the pointer advances by one. A load at slot 31 returns the pointer to the floor.
- R6: A lock write sets the floor and the pointer in the next cycle. This holds even when the pointer is set below the floor, and the next load then goes to that slot.
- R7: A single flush clears every valid slot whose size equals the staged size code and whose tag matches the staged tag in the bits that size compares. It clears such a slot whatever its keep flag.
- R8: A global flush clears every slot whose keep flag is 0 and leaves slots with the flag set valid.
- R9: When several valid slots match an address, the output comes from the lowest-numbered one.
- R10: On a miss, the hit flag, the output address and all attribute outputs are 0.
- R11: A slot loaded with its valid flag at 0 never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cam_we | input | 1 | Write the staged tag word |
| cam_wdata | input | 32 | Tag word: tag, keep, valid, size |
| ram_we | input | 1 | Write the staged data word |
| ram_wdata | input | 32 | Data word: physical base and attributes |
| lock_we | input | 1 | Write the floor and the pointer |
| lock_base_i | input | 5 | New locked floor |
| lock_victim_i | input | 5 | New replacement pointer |
| load_i | input | 1 | Load the staged words into the pointed slot |
| flush_one_i | input | 1 | Flush the slots matching the staged tag word |
| flush_all_i | input | 1 | Flush all slots that are not kept |
| va_i | input | 32 | Lookup virtual address |
| pa_o | output | 32 | Translated physical address |
| hit_o | output | 1 | Lookup hit |
| endian_o | output | 1 | Endianness attribute of the hit slot |
| elsize_o | output | 2 | Element-size attribute of the hit slot |
| mixed_o | output | 1 | Mixed-size attribute of the hit slot |
| lock_base_o | output | 5 | Current locked floor |
| victim_o | output | 5 | Current replacement pointer |

## Verification
A wrong valid bit or a wrong size mask in a slot is visible on the lookup outputs as soon as the slot is addressed. It shows as a missing hit, an unexpected hit, or a physical address with its low bits taken from the wrong side. A pointer that advances or wraps wrongly shows up on `victim_o` in the cycle after the load. It also shows up later, because the loaded translation lands in the wrong slot and a pinned slot is overwritten. A flush that ignores the size or the keep flag leaves a stale translation or removes a kept one. The next lookup of that address exposes it.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 32,
  parameter int AW      = 32,
  parameter int PGB     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cam_we,
  input  logic [AW-1:0]              cam_wdata,
  input  logic                       ram_we,
  input  logic [AW-1:0]              ram_wdata,
  input  logic                       lock_we,
  input  logic [$clog2(ENTRIES)-1:0] lock_base_i,
  input  logic [$clog2(ENTRIES)-1:0] lock_victim_i,
  input  logic                       load_i,
  input  logic                       flush_one_i,
  input  logic                       flush_all_i,
  input  logic [AW-1:0]              va_i,
  output logic [AW-1:0]              pa_o,
  output logic                       hit_o,
  output logic                       endian_o,
  output logic [1:0]                 elsize_o,
  output logic                       mixed_o,
  output logic [$clog2(ENTRIES)-1:0] lock_base_o,
  output logic [$clog2(ENTRIES)-1:0] victim_o
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - PGB;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  function automatic logic [TW-1:0] size_mask(input logic [1:0] code);
    case (code)
      2'd0:    size_mask = {{(AW-20){1'b1}}, {(20-PGB){1'b0}}};
      2'd1:    size_mask = {{(AW-16){1'b1}}, {(16-PGB){1'b0}}};
      2'd2:    size_mask = {TW{1'b1}};
      default: size_mask = {{(AW-24){1'b1}}, {(24-PGB){1'b0}}};
    endcase
  endfunction

  logic [TW-1:0] st_tag, st_ppn;
  logic [1:0]    st_sz, st_esz;
  logic          st_vld, st_keep, st_end, st_mix;

  logic [TW-1:0] vtag_q [ENTRIES];
  logic [TW-1:0] ppn_q  [ENTRIES];
  logic [1:0]    sz_q   [ENTRIES];
  logic [3:0]    att_q  [ENTRIES];
  logic [ENTRIES-1:0] vld_q, keep_q, vld_nx, fmatch, hitv;
  logic [IW-1:0] base_q, vic_q, sel;

  logic unused_bits;
  assign unused_bits = ^{cam_wdata[PGB-1:4], ram_wdata[PGB-1:10], ram_wdata[5:0]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign fmatch[i] = vld_q[i] && (sz_q[i] == st_sz) &&
                       (((vtag_q[i] ^ st_tag) & size_mask(st_sz)) == '0);
    assign hitv[i]   = vld_q[i] &&
                       (((vtag_q[i] ^ va_i[AW-1:PGB]) & size_mask(sz_q[i])) == '0);
  end

  always_comb begin
    vld_nx = vld_q;
    if (flush_all_i) vld_nx = vld_nx & keep_q;
    if (flush_one_i) vld_nx = vld_nx & ~fmatch;
    if (load_i)      vld_nx[vic_q] = st_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {st_tag, st_sz, st_vld, st_keep} <= '0;
      {st_ppn, st_end, st_esz, st_mix} <= '0;
      vld_q  <= '0;
      keep_q <= '0;
      base_q <= '0;
      vic_q  <= '0;
    end else begin
      if (cam_we) begin
        st_tag  <= cam_wdata[AW-1:PGB];
        st_keep <= cam_wdata[3];
        st_vld  <= cam_wdata[2];
        st_sz   <= cam_wdata[1:0];
      end
      if (ram_we) begin
        st_ppn <= ram_wdata[AW-1:PGB];
        st_end <= ram_wdata[9];
        st_esz <= ram_wdata[8:7];
        st_mix <= ram_wdata[6];
      end
      vld_q <= vld_nx;
      if (load_i) keep_q[vic_q] <= st_keep;
      if (lock_we) begin
        base_q <= lock_base_i;
        vic_q  <= lock_victim_i;
      end else if (load_i) begin
        vic_q <= (vic_q == LAST) ? base_q : vic_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      vtag_q[vic_q] <= st_tag;
      sz_q[vic_q]   <= st_sz;
      ppn_q[vic_q]  <= st_ppn;
      att_q[vic_q]  <= {st_end, st_esz, st_mix};
    end
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hitv[i]) sel = IW'(i);
  end

  logic [TW-1:0] m_sel;
  assign m_sel = size_mask(sz_q[sel]);
  assign hit_o = |hitv;
  assign pa_o  = hit_o ? {(ppn_q[sel] & m_sel) | (va_i[AW-1:PGB] & ~m_sel), va_i[PGB-1:0]} : '0;
  assign {endian_o, elsize_o, mixed_o} = hit_o ? att_q[sel] : 4'd0;
  assign lock_base_o = base_q;
  assign victim_o    = vic_q;
endmodule

module tlb_assoc_chk #(
  parameter int ENTRIES = 32,
  parameter int AW      = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       load,
  input logic                       lock_we,
  input logic                       flush_all,
  input logic [$clog2(ENTRIES)-1:0] lock_base_i,
  input logic [$clog2(ENTRIES)-1:0] lock_vic_i,
  input logic [$clog2(ENTRIES)-1:0] base,
  input logic [$clog2(ENTRIES)-1:0] victim,
  input logic [ENTRIES-1:0]         vld,
  input logic [ENTRIES-1:0]         keep,
  input logic                       hit,
  input logic [AW-1:0]              pa
);
  localparam int IW = $clog2(ENTRIES);

  assert_victim_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !lock_we && victim != IW'(ENTRIES - 1)) |=> victim == IW'($past(victim) + 1'b1));

  assert_victim_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !lock_we && victim == IW'(ENTRIES - 1)) |=> victim == $past(base));

  assert_lock_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we |=> (base == $past(lock_base_i)) && (victim == $past(lock_vic_i)));

  assert_global_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !load) |=> (vld & ~keep) == '0);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> pa == '0);

  assert_empty_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> !hit);
endmodule

bind tlb_assoc tlb_assoc_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_i), .lock_we(lock_we), .flush_all(flush_all_i),
  .lock_base_i(lock_base_i), .lock_vic_i(lock_victim_i), .base(base_q), .victim(vic_q),
  .vld(vld_q), .keep(keep_q), .hit(hit_o), .pa(pa_o)
);

// File: tb/sim_tlb_assoc.sv
module sim_tlb_assoc;
  logic clk = 0, rst_n = 0;
  logic cam_we = 0, ram_we = 0, lock_we = 0, load_i = 0, flush_one_i = 0, flush_all_i = 0;
  logic [31:0] cam_wdata = 0, ram_wdata = 0, va_i = 0;
  logic [4:0] lock_base_i = 0, lock_victim_i = 0;
  logic [31:0] pa_o;
  logic hit_o, endian_o, mixed_o;
  logic [1:0] elsize_o;
  logic [4:0] lock_base_o, victim_o;

  always #2 clk = ~clk;

  tlb_assoc u0 (.*);

  typedef struct {
    bit          kind;
    bit          hit;
    logic [31:0] pa;
    logic [3:0]  attr;
    logic [4:0]  base;
    logic [4:0]  vic;
    string       req;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  logic [4:0] e_base = 0, e_vic = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (it.kind == 0) begin
        if (hit_o !== it.hit || pa_o !== it.pa || {endian_o, elsize_o, mixed_o} !== it.attr) begin
          bad++;
          $display("FAIL %s: hit=%0b pa=%h attr=%h expected hit=%0b pa=%h attr=%h",
                   it.req, hit_o, pa_o, {endian_o, elsize_o, mixed_o}, it.hit, it.pa, it.attr);
        end
      end else if (lock_base_o !== it.base || victim_o !== it.vic) begin
        bad++;
        $display("FAIL %s: base=%0d victim=%0d expected base=%0d victim=%0d",
                 it.req, lock_base_o, victim_o, it.base, it.vic);
      end
    end
  end

  task automatic cyc;
    @(posedge clk); #1;
  endtask

  task automatic look(input logic [31:0] va, input bit h, input logic [31:0] pa,
                      input logic [3:0] attr, input string req);
    item_t it;
    cyc; va_i = va;
    it.kind = 0; it.hit = h; it.pa = pa; it.attr = attr; it.base = 0; it.vic = 0; it.req = req;
    q.push_back(it);
  endtask

  task automatic lockchk(input string req);
    item_t it;
    cyc;
    it.kind = 1; it.hit = 0; it.pa = 0; it.attr = 0; it.base = e_base; it.vic = e_vic; it.req = req;
    q.push_back(it);
  endtask

  task automatic load(input logic [31:0] cam, input logic [31:0] ram);
    cyc; cam_we = 1; ram_we = 1; cam_wdata = cam; ram_wdata = ram;
    cyc; cam_we = 0; ram_we = 0; load_i = 1;
    cyc; load_i = 0;
    e_vic = (e_vic == 5'd31) ? e_base : e_vic + 5'd1;
  endtask

  task automatic flush1(input logic [31:0] cam);
    cyc; cam_we = 1; cam_wdata = cam;
    cyc; cam_we = 0; flush_one_i = 1;
    cyc; flush_one_i = 0;
  endtask

  task automatic setlock(input logic [4:0] b, input logic [4:0] v);
    cyc; lock_we = 1; lock_base_i = b; lock_victim_i = v;
    cyc; lock_we = 0;
    e_base = b; e_vic = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    lockchk("R1 reset lock state");
    look(32'h12345678, 0, 0, 0, "R1 reset miss");
    look(32'h00000000, 0, 0, 0, "R10 miss zero");

    load(32'h12345006, 32'hABCDE340);
    look(32'h12345678, 1, 32'hABCDE678, 4'b1101, "R2 R4 4KB hit with attrs");
    lockchk("R5 advance");
    load(32'h40000004, 32'h80000000);
    look(32'h40012345, 1, 32'h80012345, 0, "R3 1MB section");
    load(32'h50010005, 32'h9ABCF000);
    look(32'h5001ABCD, 1, 32'h9ABCABCD, 0, "R3 64KB low bits from VA");
    load(32'h6000000F, 32'h01000000);
    look(32'h60ABCDEF, 1, 32'h01ABCDEF, 0, "R3 16MB supersection");
    load(32'h40012006, 32'h77777000);
    look(32'h40012345, 1, 32'h80012345, 0, "R9 lowest index wins");
    load(32'h70000002, 32'h11111000);
    look(32'h70000123, 0, 0, 0, "R11 invalid load no hit");
    lockchk("R5 six loads");

    setlock(5'd2, 5'd31);
    lockchk("R6 lock write");
    load(32'h33333006, 32'h44444000);
    lockchk("R5 wrap to base");
    look(32'h33333ABC, 1, 32'h44444ABC, 0, "R2 load at slot 31");
    load(32'h50010006, 32'h22222000);
    look(32'h5001ABCD, 0, 0, 0, "R5 slot 2 replaced");
    lockchk("R5 after wrap");

    flush1(32'h400AB000);
    look(32'h40012345, 1, 32'h77777345, 0, "R7 flush by section size");
    flush1(32'h60000003);
    look(32'h60ABCDEF, 0, 0, 0, "R7 flush ignores keep");
    load(32'h6000000F, 32'h01000000);
    look(32'h60ABCDEF, 1, 32'h01ABCDEF, 0, "R2 reload kept");

    cyc; flush_all_i = 1;
    cyc; flush_all_i = 0;
    look(32'h60ABCDEF, 1, 32'h01ABCDEF, 0, "R8 kept survives");
    look(32'h12345678, 0, 0, 0, "R8 cleared");
    look(32'h33333ABC, 0, 0, 0, "R8 cleared slot 31");

    setlock(5'd2, 5'd0);
    load(32'h12345006, 32'hABCDE340);
    lockchk("R6 pointer below floor");
    look(32'h12345678, 1, 32'hABCDE678, 4'b1101, "R6 load below floor");

    repeat (3) cyc;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule